// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable single-clock synchronous SRAM. On each rising clock edge it captures the address, the write data, three chip enables, two address strobes, a burst advance input and the write controls. Read data comes back through an output register, so it appears one cycle after the access is registered. Writes go into the array in the cycle they are registered. A two-bit internal counter produces the low two address bits of a four-beat burst. A static mode input selects linear or interleaved order for that count.

A burst can be opened by either of two active-low address strobes: a processor strobe and a controller strobe. Once a burst is open, the active-low advance input steps the counter. With advance high, the burst suspends on the same word. A deselect takes effect in a single cycle, so the output driver enable falls right after the last read data slot. The active-low output enable gates the driver combinationally, without passing through a register. Depth, lane count and lane width are parameters. The pad-level tri-state buffer sits outside the block: the block provides the value and its drive enable.

Top module: `sync_burst_sram`

## Requirements
- R1: The block is selected only when `ce_n_i` is 0, `ce2_i` is 1 and `ce3_n_i` is 0. A strobe-initiated start made while it is not selected closes any open burst, and its read slot (after the second following edge) has `q_oe_o` = 0.
- R2: A read start registered at edge N places the word at the start address on `q_o` with `q_oe_o` = 1 (given `oe_n_i` = 0) from edge N+1 until edge N+2.
- R3: With `ce_n_i` = 0 and the block selected, `adsp_n_i` = 0 starts a burst that is always a read, whatever the write controls say. With `ce_n_i` = 1, the processor strobe is ignored, and the controller strobe and advance rules decide the cycle.
- R4: With `burst_lin_i` = 1, beat k of a burst addresses the upper bits of the start address, followed by (start low two bits + k) mod 4.
- R5: With `burst_lin_i` = 0, beat k uses the start low two bits XOR k, and the upper bits are kept.
- R6: While a burst is open, a cycle with no strobe and `adv_n_i` = 1 accesses the same word again, and the counter does not move.
- R7: `gw_n_i` = 0 in an accessing cycle (other than a processor-strobe start) writes all lanes of `d_i` to the current address.
- R8: With `gw_n_i` = 1 and `bwe_n_i` = 0, lane i (bits [i*LANE_W +: LANE_W]) is written only where `bw_n_i[i]` = 0. If no lane is enabled, or `bwe_n_i` = 1, the cycle is a read.
- R9: A read registered at edge N, followed by a deselect at edge N+1, drives data only between edges N+1 and N+2. `q_oe_o` is 0 after edge N+2.
- R10: `oe_n_i` = 1 forces `q_oe_o` to 0 at once, without waiting for a clock edge.
- R11: After reset, `q_oe_o` is 0 and no burst is open, so an advance alone causes no access.
- R12: A write cycle's output slot has `q_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| addr_i | input | ADDR_W | Word address |
| d_i | input | LANES*LANE_W | Write data |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Second chip enable, active high |
| ce3_n_i | input | 1 | Third chip enable, active low |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bw_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| q_o | output | LANES*LANE_W | Registered read data |
| q_oe_o | output | 1 | Output driver enable for the data pad |

## Verification
The hardest conditions to reach from the ports come up while a burst is still open: a processor strobe raised with the primary enable high, which must fall through to an advance, and a deselect that lands one cycle after a read. A random stream that opens bursts evenly would seldom hit either at the right moment. The bench therefore builds them as directed sequences, and also checks the data and driver enable in every cycle of a long seeded random run. In that run, strobes, enables and advances are weighted so that bursts often stay open across several beats and wrap through both orders.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_START_P,
        CYC_START_C,
        CYC_ADV,
        CYC_HOLD
    } cyc_e;

    // low two address bits of beat 'cnt' for a burst opened at 'base'
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        logic [1:0] sum;
        sum = base + cnt;
        return lin ? sum : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              ce2_i,
    input  logic              ce3_n_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic              burst_lin_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [LANES-1:0]  bw_n_i,
    output logic              acc_vld_o,
    output logic              acc_wr_o,
    output logic [LANES-1:0]  acc_lanes_o,
    output logic [ADDR_W-1:0] acc_addr_o
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } ctl_t;

    ctl_t             st_d, st_q;
    cyc_e             kind;
    logic             sel;
    logic [LANES-1:0] lanes_req;
    logic [HI_W-1:0]  hi_bits;

    always_comb begin
        sel = !ce_n_i && ce2_i && !ce3_n_i;

        // processor strobe only counts with the primary enable low
        if (!adsp_n_i && !ce_n_i)
            kind = sel ? CYC_START_P : CYC_DESEL;
        else if (!adsc_n_i)
            kind = sel ? CYC_START_C : CYC_DESEL;
        else if (st_q.active)
            kind = adv_n_i ? CYC_HOLD : CYC_ADV;
        else
            kind = CYC_IDLE;

        if (!gw_n_i)
            lanes_req = '1;
        else if (!bwe_n_i)
            lanes_req = ~bw_n_i;
        else
            lanes_req = '0;

        st_d      = st_q;
        acc_vld_o = 1'b0;
        case (kind)
            CYC_DESEL: st_d.active = 1'b0;
            CYC_START_P, CYC_START_C: begin
                st_d.active = 1'b1;
                st_d.base   = addr_i;
                st_d.cnt    = 2'd0;
                acc_vld_o   = 1'b1;
            end
            CYC_ADV: begin
                st_d.cnt  = st_q.cnt + 2'd1;
                acc_vld_o = 1'b1;
            end
            CYC_HOLD: acc_vld_o = 1'b1;
            default: ;
        endcase

        acc_wr_o    = acc_vld_o && (kind != CYC_START_P) && (|lanes_req);
        acc_lanes_o = acc_wr_o ? lanes_req : '0;
        hi_bits     = st_d.base[ADDR_W-1:2];
        acc_addr_o  = {hi_bits, burst_low(st_d.base[1:0], st_d.cnt, burst_lin_i)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_vld_i,
    input  logic                    acc_wr_i,
    input  logic [LANES-1:0]        acc_lanes_i,
    input  logic [ADDR_W-1:0]       acc_addr_i,
    input  logic [LANES*LANE_W-1:0] d_i,
    output logic                    drv_o,
    output logic [LANES*LANE_W-1:0] q_o
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] raddr;
        logic              drv;
        logic [DW-1:0]     dout;
    } pipe_t;

    logic [DW-1:0] mem [DEPTH];
    pipe_t         pipe_d, pipe_q;

    // write lands in the cycle it is registered
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (acc_vld_i && acc_lanes_i[l])
                mem[acc_addr_i][l*LANE_W +: LANE_W] <= d_i[l*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.rd    = acc_vld_i && !acc_wr_i;
        pipe_d.raddr = acc_addr_i;
        pipe_d.drv   = pipe_q.rd;
        if (pipe_q.rd)
            pipe_d.dout = mem[pipe_q.raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign drv_o = pipe_q.drv;
    assign q_o   = pipe_q.dout;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] d_i,
    input  logic                    ce_n_i,
    input  logic                    ce2_i,
    input  logic                    ce3_n_i,
    input  logic                    adsp_n_i,
    input  logic                    adsc_n_i,
    input  logic                    adv_n_i,
    input  logic                    burst_lin_i,
    input  logic                    gw_n_i,
    input  logic                    bwe_n_i,
    input  logic [LANES-1:0]        bw_n_i,
    input  logic                    oe_n_i,
    output logic [LANES*LANE_W-1:0] q_o,
    output logic                    q_oe_o
);

    logic              acc_vld;
    logic              acc_wr;
    logic [LANES-1:0]  acc_lanes;
    logic [ADDR_W-1:0] acc_addr;
    logic              drv;

    sbs_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .ce_n_i      (ce_n_i),
        .ce2_i       (ce2_i),
        .ce3_n_i     (ce3_n_i),
        .adsp_n_i    (adsp_n_i),
        .adsc_n_i    (adsc_n_i),
        .adv_n_i     (adv_n_i),
        .burst_lin_i (burst_lin_i),
        .gw_n_i      (gw_n_i),
        .bwe_n_i     (bwe_n_i),
        .bw_n_i      (bw_n_i),
        .acc_vld_o   (acc_vld),
        .acc_wr_o    (acc_wr),
        .acc_lanes_o (acc_lanes),
        .acc_addr_o  (acc_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_vld_i   (acc_vld),
        .acc_wr_i    (acc_wr),
        .acc_lanes_i (acc_lanes),
        .acc_addr_i  (acc_addr),
        .d_i         (d_i),
        .drv_o       (drv),
        .q_o         (q_o)
    );

    // output enable gates the driver without a register
    assign q_oe_o = drv && !oe_n_i;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n_i,
    input logic             ce2_i,
    input logic             ce3_n_i,
    input logic             adsp_n_i,
    input logic             adsc_n_i,
    input logic             gw_n_i,
    input logic             bwe_n_i,
    input logic [LANES-1:0] bw_n_i,
    input logic             oe_n_i,
    input logic             q_oe_o
);

    logic chip_on;
    logic p_start;
    logic c_path;
    assign chip_on = !ce_n_i && ce2_i && !ce3_n_i;
    assign p_start = !adsp_n_i && !ce_n_i;
    assign c_path  = !p_start && !adsc_n_i;

    AST_OE_GATES_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !q_oe_o); // R10

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_start || c_path) && !chip_on) |-> ##2 !q_oe_o); // R1

    AST_PSTART_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (p_start && chip_on) |-> ##2 (q_oe_o == !oe_n_i)); // R3

    AST_CSTART_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_path && chip_on && gw_n_i && (bwe_n_i || (&bw_n_i))) |-> ##2 (q_oe_o == !oe_n_i)); // R2

    AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_path && chip_on && !gw_n_i) |-> ##2 !q_oe_o); // R12

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n_i   (ce_n_i),
    .ce2_i    (ce2_i),
    .ce3_n_i  (ce3_n_i),
    .adsp_n_i (adsp_n_i),
    .adsc_n_i (adsc_n_i),
    .gw_n_i   (gw_n_i),
    .bwe_n_i  (bwe_n_i),
    .bw_n_i   (bw_n_i),
    .oe_n_i   (oe_n_i),
    .q_oe_o   (q_oe_o)
);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;

    localparam int PER    = 10;
    localparam int ADDR_W = 8;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] a = '0;
    logic [DW-1:0] din = '0;
    logic ce_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic lin = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [LANES-1:0] bw_n = '1;
    logic [DW-1:0] q;
    logic q_oe;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R11";
    logic probe_oe = 1'b0;

    // expectation state derived from the requirements
    logic [DW-1:0]     refmem [DEPTH];
    logic              m_act = 1'b0;
    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_cnt = '0;
    logic              e_rd = 1'b0, e_drv = 1'b0;
    logic [ADDR_W-1:0] e_raddr = '0;
    logic [DW-1:0]     e_dout = '0;

    always #(PER/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(a), .d_i(din),
        .ce_n_i(ce_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
        .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n),
        .burst_lin_i(lin), .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n),
        .oe_n_i(oe_n), .q_o(q), .q_oe_o(q_oe)
    );

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic model_edge();
        logic sel, vld, wr, pst;
        logic [LANES-1:0] ln;
        logic [1:0] lo;
        logic [ADDR_W-1:0] ad;
        if (e_rd) e_dout = refmem[e_raddr];
        e_drv = e_rd;
        if (!rst_n) begin
            m_act = 0; m_cnt = 0; m_base = 0; e_rd = 0; e_drv = 0; e_raddr = 0; e_dout = 0;
            return;
        end
        sel = !ce_n && ce2 && !ce3_n;
        vld = 0; pst = 0;
        if (!adsp_n && !ce_n) begin
            if (sel) begin m_act = 1; m_base = a; m_cnt = 0; vld = 1; pst = 1; end
            else m_act = 0;
        end else if (!adsc_n) begin
            if (sel) begin m_act = 1; m_base = a; m_cnt = 0; vld = 1; end
            else m_act = 0;
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            vld = 1;
        end
        ln = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
        wr = vld && !pst && (|ln);
        lo = lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        ad = {m_base[ADDR_W-1:2], lo};
        if (wr)
            for (int l = 0; l < LANES; l++)
                if (ln[l]) refmem[ad][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
        e_rd = vld && !wr;
        e_raddr = ad;
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " drive"}, 32'(q_oe), 32'(e_drv && !oe_n));
        if (e_drv) chk({tag, " data"}, 32'(q), 32'(e_dout));
        if (probe_oe && e_drv && !oe_n) begin
            oe_n = 1'b1; #1;
            chk("R10 async oe", 32'(q_oe), 32'd0);
            oe_n = 1'b0; #1;
        end
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
        ce_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic stop_burst();
        quiet(); ce2 = 0; adsc_n = 0; cyc();
        quiet(); cyc(); cyc();
    endtask

    task automatic start_c(input logic [ADDR_W-1:0] ad, input logic wr_all);
        quiet(); a = ad; adsc_n = 0; gw_n = !wr_all; din = DW'($urandom); cyc();
    endtask

    task automatic beats(input int n, input logic wr_all);
        for (int i = 0; i < n; i++) begin
            quiet(); adv_n = 0; gw_n = !wr_all; din = DW'($urandom); cyc();
        end
    endtask

    initial begin
        #(PER*200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < DEPTH; i++) refmem[i] = '0;
        tag = "R11"; quiet();
        cyc(); cyc();
        rst_n = 1'b1;
        chk("R11 reset drive", 32'(q_oe), 32'd0);
        quiet(); adv_n = 0; cyc(); cyc(); cyc();

        // fill the array with global writes over linear bursts
        tag = "R7"; lin = 1;
        for (int b = 0; b < DEPTH/4; b++) begin
            start_c(ADDR_W'(b*4), 1'b1);
            beats(3, 1'b1);
        end
        stop_burst();

        tag = "R2"; start_c(8'd77, 1'b0); stop_burst();
        tag = "R4"; lin = 1; start_c(8'd9, 1'b0); beats(4, 1'b0); stop_burst();
        tag = "R5"; lin = 0; start_c(8'd9, 1'b0); beats(4, 1'b0); stop_burst();
        tag = "R5"; start_c(8'd30, 1'b0); beats(3, 1'b0); stop_burst();
        lin = 1;

        tag = "R6"; start_c(8'd21, 1'b0);
        quiet(); cyc(); cyc(); beats(1, 1'b0); quiet(); cyc(); stop_burst();

        tag = "R8"; quiet(); a = 8'd33; adsc_n = 0; bwe_n = 0; bw_n = 2'b10; din = DW'($urandom); cyc();
        quiet(); a = 8'd34; adsc_n = 0; bwe_n = 0; bw_n = 2'b01; din = DW'($urandom); cyc();
        quiet(); a = 8'd35; adsc_n = 0; bwe_n = 0; bw_n = 2'b11; din = DW'($urandom); cyc();
        quiet(); a = 8'd36; adsc_n = 0; bwe_n = 1; bw_n = 2'b00; din = DW'($urandom); cyc();
        stop_burst();
        start_c(8'd33, 1'b0); beats(3, 1'b0); stop_burst();

        tag = "R3"; quiet(); a = 8'd40; adsp_n = 0; gw_n = 0; din = DW'($urandom); cyc();
        quiet(); adv_n = 0; adsp_n = 0; ce_n = 1; cyc();
        quiet(); adv_n = 0; adsp_n = 0; ce_n = 1; cyc();
        stop_burst();
        start_c(8'd40, 1'b0); beats(2, 1'b0); stop_burst();

        tag = "R9"; start_c(8'd50, 1'b0); quiet(); ce_n = 1; adsc_n = 0; cyc(); quiet(); cyc(); cyc();
        start_c(8'd51, 1'b0); quiet(); ce3_n = 1; adsc_n = 0; cyc(); quiet(); cyc(); cyc();
        tag = "R1"; start_c(8'd52, 1'b0); quiet(); ce2 = 0; adsc_n = 0; cyc(); quiet(); cyc(); cyc();
        quiet(); ce_n = 0; ce2 = 0; adsp_n = 0; a = 8'd60; cyc(); quiet(); cyc(); cyc();

        tag = "R12"; start_c(8'd70, 1'b1); quiet(); cyc(); stop_burst();

        tag = "R10"; probe_oe = 1; start_c(8'd80, 1'b0); beats(3, 1'b0); stop_burst(); probe_oe = 0;

        // seeded random traffic, weighted to keep bursts open
        tag = "R2 random";
        for (int i = 0; i < 4000; i++) begin
            a      = ADDR_W'($urandom);
            din    = DW'($urandom);
            adsp_n = ($urandom_range(0, 9) != 0);
            adsc_n = ($urandom_range(0, 5) != 0);
            adv_n  = ($urandom_range(0, 3) == 0);
            ce_n   = ($urandom_range(0, 7) == 0);
            ce2    = ($urandom_range(0, 9) != 0);
            ce3_n  = ($urandom_range(0, 11) == 0);
            gw_n   = ($urandom_range(0, 4) != 0);
            bwe_n  = ($urandom_range(0, 2) != 0);
            bw_n   = LANES'($urandom);
            oe_n   = ($urandom_range(0, 6) == 0);
            if ($urandom_range(0, 49) == 0) lin = ~lin;
            probe_oe = ($urandom_range(0, 9) == 0);
            cyc();
        end
        probe_oe = 0; oe_n = 0;
        stop_burst();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule